// File: doc/BRIEF.md
# Packed Dual Saturating Absolute Unit

This block is a pipelined execution unit for a datapath cluster. It takes one 32-bit operand that holds two signed 16-bit values side by side. It returns a 32-bit word in which each value is replaced by its magnitude. The single magnitude that does not fit, that of the most negative value, is pinned to the largest positive 16-bit number instead of wrapping around.

Each issued operation carries a predicate word, a destination tag and a second source operand. The second source operand must be zero by convention and does not enter the arithmetic. Two clock cycles after issue, the unit presents the result together with its tag, a valid strobe and a write-enable. The write-enable is qualified by the predicate. A new operation may be issued on every cycle.

The reset input is asynchronous and active low. Its release is synchronised inside the block before it reaches the pipeline.

Top module: `dual_sat_abs`

## Requirements
- R1: Bits 15:0 and bits 31:16 of `opb_i` are two separate signed 16-bit lanes. Each lane's result goes to the same bit positions of `res_o`, and a value in one lane never changes the other lane's result.
- R2: A lane input of 0x8000 gives a lane result of 0x7fff.
- R3: A lane input with bit 15 clear passes through unchanged. Any other negative lane input gives its two's-complement negation. Bit 15 of every lane result is therefore 0.
- R4: `wr_en_o` is 1 only for a valid result whose operation either had `guard_en_i` low or had bit 0 of `guard_i` set. Bits 31:1 of `guard_i` have no effect.
- R5: `vld_o`, `res_o`, `tag_o` and `wr_en_o` for an operation sampled with `iss_vld_i` high at one rising edge appear after the second rising edge that follows it. Back-to-back operations each keep their own tag and enable.
- R6: While reset is asserted, and until the first operation issued after reset reaches the output, `vld_o` and `wr_en_o` stay 0.
- R7: `opa_i` does not change `res_o`. `opa_nz_o` is 1 with a valid result exactly when that operation's `opa_i` was nonzero.
- R8: These fixed pairs hold: 0xffff0032 gives 0x00010032, 0x80008001 gives 0x7fff7fff, 0x0032ffff gives 0x00320001, and 0x7fffffff gives 0x7fff0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld_i | input | 1 | Operation issued this cycle |
| guard_en_i | input | 1 | Operation carries a predicate |
| guard_i | input | 32 | Predicate word, only bit 0 used |
| opa_i | input | 32 | First source, required zero |
| opb_i | input | 32 | Packed pair of signed halfwords |
| tag_i | input | 5 | Destination register tag |
| vld_o | output | 1 | Result valid |
| wr_en_o | output | 1 | Destination write-enable |
| res_o | output | 32 | Packed clipped magnitudes |
| tag_o | output | 5 | Tag of the returning result |
| opa_nz_o | output | 1 | Debug flag: first source was nonzero |

## Verification
Every pairing of the values 0x0000, 0x0001, 0x7fff, 0x8000, 0x8001 and 0xffff across the two lanes is issued. These cases separate the clipping of 0x8000 from plain negation and from pass-through, and they show any leakage between the lanes. The fixed vector pairs and a long run of random words, with corner values mixed in, follow. Some of these operations have no gap between them, and others have idle cycles in between; this shows whether tags and enables stay aligned with their data. The predicate is tested in several combinations: absent, present and true, present and false, and present with only the upper bits set. A nonzero first operand confirms that only the debug flag reacts to it.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  // Control bits that travel alongside each lane-result word.
  typedef struct packed {
    logic vld;
    logic wr;
    logic nz;
  } dsa_ctl_t;

  localparam dsa_ctl_t DSA_CTL_IDLE = '{vld: 1'b0, wr: 1'b0, nz: 1'b0};

endpackage

// File: rtl/dsa_rst_sync.sv
module dsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/dsa_lane.sv
module dsa_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = ~MOST_NEG;

  always_comb begin
    if (x_i == MOST_NEG) begin
      y_o = MOST_POS;
    end else if (x_i[W-1]) begin
      y_o = (~x_i) + {{(W-1){1'b0}}, 1'b1};
    end else begin
      y_o = x_i;
    end
  end

endmodule

// File: rtl/dsa_stage.sv
module dsa_stage
  import dsa_pkg::*;
#(
  parameter int DW    = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  dsa_ctl_t         ctl_i,
  input  logic [DW-1:0]    dat_i,
  input  logic [TAG_W-1:0] tag_i,
  output dsa_ctl_t         ctl_o,
  output logic [DW-1:0]    dat_o,
  output logic [TAG_W-1:0] tag_o
);

  dsa_ctl_t         ctl_q;
  logic [DW-1:0]    dat_q, dat_nxt;
  logic [TAG_W-1:0] tag_q, tag_nxt;

  // Clock enable: payload only moves with a valid operation.
  always_comb begin
    dat_nxt = dat_q;
    tag_nxt = tag_q;
    if (ctl_i.vld) begin
      dat_nxt = dat_i;
      tag_nxt = tag_i;
    end
  end

  always_ff @(posedge clk) begin
    dat_q <= dat_nxt;
    tag_q <= tag_nxt;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctl_q <= DSA_CTL_IDLE;
    end else begin
      ctl_q <= ctl_i;
    end
  end

  assign ctl_o = ctl_q;
  assign dat_o = dat_q;
  assign tag_o = tag_q;

endmodule

// File: rtl/dual_sat_abs.sv
module dual_sat_abs
  import dsa_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int NLANE  = 2,
  parameter int TAG_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_vld_i,
  input  logic                    guard_en_i,
  input  logic [LANE_W*NLANE-1:0] guard_i,
  input  logic [LANE_W*NLANE-1:0] opa_i,
  input  logic [LANE_W*NLANE-1:0] opb_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic                    vld_o,
  output logic                    wr_en_o,
  output logic [LANE_W*NLANE-1:0] res_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic                    opa_nz_o
);

  localparam int DW  = LANE_W * NLANE;
  localparam int LAT = 2;

  logic rst_q_n;

  dsa_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  logic [DW-1:0] lane_res;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dsa_lane #(.W(LANE_W)) u_lane (
      .x_i (opb_i[g*LANE_W +: LANE_W]),
      .y_o (lane_res[g*LANE_W +: LANE_W])
    );
  end

  // Only the predicate's lowest bit matters; the rest is dropped.
  logic unused_guard_hi;
  assign unused_guard_hi = ^guard_i[DW-1:1];

  dsa_ctl_t         ctl_s [LAT+1];
  logic [DW-1:0]    dat_s [LAT+1];
  logic [TAG_W-1:0] tag_s [LAT+1];

  always_comb begin
    ctl_s[0].vld = iss_vld_i;
    ctl_s[0].wr  = iss_vld_i & (~guard_en_i | guard_i[0]);
    ctl_s[0].nz  = |opa_i;
    dat_s[0]     = lane_res;
    tag_s[0]     = tag_i;
  end

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    dsa_stage #(.DW(DW), .TAG_W(TAG_W)) u_stage (
      .clk     (clk),
      .rst_q_n (rst_q_n),
      .ctl_i   (ctl_s[s]),
      .dat_i   (dat_s[s]),
      .tag_i   (tag_s[s]),
      .ctl_o   (ctl_s[s+1]),
      .dat_o   (dat_s[s+1]),
      .tag_o   (tag_s[s+1])
    );
  end

  assign vld_o    = ctl_s[LAT].vld;
  assign wr_en_o  = ctl_s[LAT].wr;
  assign opa_nz_o = ctl_s[LAT].vld & ctl_s[LAT].nz;
  assign res_o    = dat_s[LAT];
  assign tag_o    = tag_s[LAT];

endmodule

// File: rtl/dsa_chk.sv
module dsa_chk #(
  parameter int LANE_W = 16,
  parameter int NLANE  = 2,
  parameter int TAG_W  = 5
) (
  input logic                    clk,
  input logic                    rst_q_n,
  input logic                    iss_vld_i,
  input logic                    guard_en_i,
  input logic                    guard_b0,
  input logic [LANE_W*NLANE-1:0] opa_i,
  input logic [LANE_W*NLANE-1:0] opb_i,
  input logic [TAG_W-1:0]        tag_i,
  input logic                    vld_o,
  input logic                    wr_en_o,
  input logic [LANE_W*NLANE-1:0] res_o,
  input logic [TAG_W-1:0]        tag_o,
  input logic                    opa_nz_o
);

  localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};

  // Cycles since internal reset release, saturating; two past samples needed.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  logic armed;
  assign armed = (since_rst >= 2'd2);

  always @(posedge clk) begin
    if (!rst_q_n) begin
      assert_quiet_in_reset_R6: assert (!vld_o && !wr_en_o)
        else $error("output active during reset");
    end
  end

  assert_wr_needs_vld_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_en_o |-> vld_o);

  assert_guard_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    armed |-> (wr_en_o == ($past(iss_vld_i, 2) &&
                           (!$past(guard_en_i, 2) || $past(guard_b0, 2)))));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    armed |-> (vld_o == $past(iss_vld_i, 2)));

  assert_tag_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && vld_o) |-> (tag_o == $past(tag_i, 2)));

  assert_dbg_flag_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && vld_o) |-> (opa_nz_o == ($past(opa_i, 2) != '0)));

  for (genvar g = 0; g < NLANE; g++) begin : g_lane_chk
    assert_range_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
      vld_o |-> !res_o[g*LANE_W + LANE_W - 1]);

    assert_clip_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
      (armed && vld_o && ($past(opb_i[g*LANE_W +: LANE_W], 2) == MOST_NEG))
      |-> (res_o[g*LANE_W +: LANE_W] == ~MOST_NEG));

    assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
      (armed && vld_o && !$past(opb_i[g*LANE_W + LANE_W - 1], 2))
      |-> (res_o[g*LANE_W +: LANE_W] == $past(opb_i[g*LANE_W +: LANE_W], 2)));
  end

endmodule

bind dual_sat_abs dsa_chk #(
  .LANE_W (LANE_W),
  .NLANE  (NLANE),
  .TAG_W  (TAG_W)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .iss_vld_i  (iss_vld_i),
  .guard_en_i (guard_en_i),
  .guard_b0   (guard_i[0]),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .tag_i      (tag_i),
  .vld_o      (vld_o),
  .wr_en_o    (wr_en_o),
  .res_o      (res_o),
  .tag_o      (tag_o),
  .opa_nz_o   (opa_nz_o)
);

// File: tb/sim_dual_sat_abs.sv
`timescale 1ns/1ps
module sim_dual_sat_abs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_vld_i, guard_en_i;
  logic [31:0] guard_i, opa_i, opb_i;
  logic [4:0]  tag_i;
  logic        vld_o, wr_en_o, opa_nz_o;
  logic [31:0] res_o;
  logic [4:0]  tag_o;

  always #2.5 clk = ~clk;

  dual_sat_abs u0 (
    .clk(clk), .rst_n(rst_n), .iss_vld_i(iss_vld_i), .guard_en_i(guard_en_i),
    .guard_i(guard_i), .opa_i(opa_i), .opb_i(opb_i), .tag_i(tag_i),
    .vld_o(vld_o), .wr_en_o(wr_en_o), .res_o(res_o), .tag_o(tag_o),
    .opa_nz_o(opa_nz_o)
  );

  typedef struct {
    logic [31:0] res;
    logic [4:0]  tag;
    logic        wr;
    logic        nz;
    int          due;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 0;
  logic [4:0] tag_ctr = 5'd0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_lane(input logic [15:0] x);
    if (x == 16'h8000) return 16'h7fff;
    if (x[15]) return 16'h0000 - x;
    return x;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] w);
    return {ref_lane(w[31:16]), ref_lane(w[15:0])};
  endfunction

  // Driver: drives on the falling edge and records the expected result.
  task automatic issue(input logic [31:0] b, input logic [31:0] a,
                       input logic gen, input logic [31:0] g, input string req);
    exp_t e;
    @(negedge clk);
    iss_vld_i  = 1'b1;
    guard_en_i = gen;
    guard_i    = g;
    opa_i      = a;
    opb_i      = b;
    tag_i      = tag_ctr;
    e.res = ref_word(b);
    e.tag = tag_ctr;
    e.wr  = !gen || g[0];
    e.nz  = (a != 32'd0);
    e.due = cyc + 2;
    e.req = req;
    exp_q.push_back(e);
    tag_ctr = tag_ctr + 5'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      iss_vld_i = 1'b0;
      opb_i     = $urandom;
      opa_i     = $urandom;
      guard_i   = $urandom;
      tag_i     = 5'(($urandom));
    end
  endtask

  // Monitor: one item per valid result, checked in the cycle it is due.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (vld_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected result", {27'd0, tag_o}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.due, "R5", "latency", cyc, e.due);
          chk(res_o == e.res, e.req, "result", res_o, e.res);
          chk(tag_o == e.tag, "R5", "tag", {27'd0, tag_o}, {27'd0, e.tag});
          chk(wr_en_o == e.wr, "R4", "write-enable", {31'd0, wr_en_o}, {31'd0, e.wr});
          chk(opa_nz_o == e.nz, "R7", "debug flag", {31'd0, opa_nz_o}, {31'd0, e.nz});
        end
      end else begin
        chk(!wr_en_o, "R4", "write without valid", {31'd0, wr_en_o}, 32'd0);
        if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
          chk(1'b0, "R5", "missing result", cyc, exp_q[0].due);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] corner [6];
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7fff;
    corner[3] = 16'h8000; corner[4] = 16'h8001; corner[5] = 16'hffff;

    rst_n = 1'b0; iss_vld_i = 1'b0; guard_en_i = 1'b0;
    guard_i = '0; opa_i = '0; opb_i = '0; tag_i = '0;

    // R6: quiet while in reset, even with issues presented.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      iss_vld_i = 1'b1;
      #1;
      chk(!vld_o && !wr_en_o, "R6", "outputs in reset",
          {30'd0, vld_o, wr_en_o}, 32'd0);
    end
    @(negedge clk);
    iss_vld_i = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!vld_o && !wr_en_o, "R6", "outputs after release",
          {30'd0, vld_o, wr_en_o}, 32'd0);
    end

    // R8: fixed pairs.
    issue(32'hffff0032, 32'd0, 1'b0, 32'd0, "R8");
    issue(32'h80008001, 32'd0, 1'b1, 32'd0, "R8");
    issue(32'h80008001, 32'd0, 1'b1, 32'd1, "R8");
    issue(32'h0032ffff, 32'd0, 1'b0, 32'd0, "R8");
    issue(32'h7fffffff, 32'd0, 1'b0, 32'd0, "R8");
    idle(3);

    // R1, R2, R3: every corner pair across the lanes, back to back.
    for (int h = 0; h < 6; h++)
      for (int l = 0; l < 6; l++)
        issue({corner[h], corner[l]}, 32'd0, 1'b0, 32'd0,
              (corner[h] == 16'h8000 || corner[l] == 16'h8000) ? "R2" : "R1");
    idle(2);

    // R4: predicate variants; upper bits alone never enable a write.
    issue(32'h12348765, 32'd0, 1'b1, 32'hfffffffe, "R4");
    issue(32'h12348765, 32'd0, 1'b1, 32'h00000001, "R4");
    issue(32'h12348765, 32'd0, 1'b0, 32'hfffffffe, "R4");
    idle(1);
    issue(32'h8000ffff, 32'd0, 1'b1, 32'h80000000, "R4");
    idle(3);

    // R7: nonzero first operand leaves the result alone.
    issue(32'hfffe0005, 32'hdeadbeef, 1'b0, 32'd0, "R7");
    issue(32'hfffe0005, 32'd0, 1'b0, 32'd0, "R7");
    issue(32'h80000001, 32'h00000001, 1'b0, 32'd0, "R7");
    idle(3);

    // R3, R5: random words with corners mixed in and random gaps.
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 3) == 0) w[15:0]  = corner[$urandom_range(0, 5)];
      if ($urandom_range(0, 3) == 0) w[31:16] = corner[$urandom_range(0, 5)];
      issue(w, ($urandom_range(0, 7) == 0) ? $urandom : 32'd0,
            1'($urandom), $urandom, "R3");
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
    end
    idle(6);

    chk(exp_q.size() == 0, "R5", "results outstanding", exp_q.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule